// File: doc/BRIEF.md
# Double-Block Packed SAD Unit

This block computes sums of absolute differences between unsigned bytes of two packed vectors. The second operand is first rearranged dword by dword inside each 128-bit lane under an 8-bit shuffle control. Each 64-bit superblock then produces four 16-bit results. Each result compares one of two fixed dwords from the first operand with a window of four bytes that slides through the rearranged vector. A write mask per result word then either keeps each computed word, or replaces it with the prior destination word or with zero.

A parameter sets the vector width to 128, 256 or 512 bits. Operands arrive with a valid strobe. The result leaves a single output register one clock later, together with its own valid flag. It is meant to sit in a vector execution pipeline behind decode and operand fetch.

Top module: `dbsad_unit`

## Requirements
- R1: Rearranged dword k (k = 0..3) of every 128-bit lane is the dword of the same lane of `srcB` chosen by `shufCtl[2k+1:2k]`. Code 0 picks dword 0 (bits 31:0 of the lane), 1 picks dword 1, 2 picks dword 2 and 3 picks dword 3.
- R2: Every lane uses the same `shufCtl`, and no dword moves from one 128-bit lane to another.
- R3: In each 64-bit superblock, result word 0 (bits 15:0) sums |A[i] − T[i]| for i = 0..3. Word 1 (bits 31:16) sums |A[i] − T[i+1]|. A is a byte of `srcA` and T a byte of the rearranged vector, both indexed from the superblock start.
- R4: In each superblock, word 2 (bits 47:32) sums |A[4+i] − T[2+i]| for i = 0..3, and word 3 (bits 63:48) sums |A[4+i] − T[3+i]|.
- R5: Bytes are unsigned, so a result lies in 0..1020 and is zero-extended to 16 bits. 0x00 against 0xFF in all four byte pairs gives 1020.
- R6: When `maskEnable` is low, every word takes its computed result, whatever `wordMask` holds.
- R7: When `maskEnable` is high and `zeroMode` is low, word j takes its result if `wordMask[j]` is 1. Otherwise it takes word j of `priorDest`.
- R8: When `maskEnable` and `zeroMode` are both high, word j is 0 if `wordMask[j]` is 0.
- R9: A cycle with `inValid` high updates `result` and raises `outValid` at the next rising clock edge, one cycle of latency.
- R10: A cycle with `inValid` low leaves `result` unchanged and drives `outValid` low after the next edge.
- R11: Synchronous active-high `rst` clears `result` and `outValid`, even when `inValid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operands valid this cycle |
| srcA | input | VEC_W | First operand, holds the stationary dwords |
| srcB | input | VEC_W | Second operand, rearranged per lane |
| shufCtl | input | 8 | Dword selection, two bits per destination dword |
| wordMask | input | VEC_W/16 | One enable bit per result word |
| maskEnable | input | 1 | Apply `wordMask` when high |
| zeroMode | input | 1 | Masked-off words become zero (high) or keep `priorDest` (low) |
| priorDest | input | VEC_W | Previous destination value used for merging |
| outValid | output | 1 | `result` was loaded at the last edge |
| result | output | VEC_W | Registered packed 16-bit results |

## Verification
The bench builds the unit with VEC_W = 256. That gives two 128-bit lanes and four superblocks. Lane isolation (R2) and the sliding window across superblock boundaries can then be observed, along with a 16-bit mask whose bits map to distinct words. All 256 shuffle controls are swept. The byte extremes and mask patterns with all ones, all zeros and random bits are applied in both mask modes. Idle cycles with changing inputs are interleaved between them.

// File: rtl/dbsad_pkg.sv
package dbsad_pkg;
  localparam int BYTE_W = 8;
  localparam int LANE_W = 128;
  localparam int SB_W   = 64;
  localparam int WORD_W = 16;
  localparam int SAD_W  = 11;

  typedef struct packed {
    logic capture;
    logic flush;
  } dbsadStrobe_t;
endpackage

// File: rtl/dbsad_lane_shuffle.sv
module dbsad_lane_shuffle #(
  parameter int VEC_W = 128
) (
  input  logic [VEC_W-1:0] srcB,
  input  logic [7:0]       shufCtl,
  output logic [VEC_W-1:0] shuffled
);
  import dbsad_pkg::*;
  localparam int N_LANES = VEC_W / LANE_W;
  localparam int DW_W    = 32;

  for (genvar ln = 0; ln < N_LANES; ln++) begin : g_lane
    logic [LANE_W-1:0] laneIn;
    assign laneIn = srcB[ln*LANE_W +: LANE_W];
    for (genvar k = 0; k < 4; k++) begin : g_dw
      logic [1:0]      sel;
      logic [DW_W-1:0] pick;
      assign sel = shufCtl[2*k +: 2];
      always_comb begin
        case (sel)
          2'd0:    pick = laneIn[0*DW_W +: DW_W];
          2'd1:    pick = laneIn[1*DW_W +: DW_W];
          2'd2:    pick = laneIn[2*DW_W +: DW_W];
          default: pick = laneIn[3*DW_W +: DW_W];
        endcase
      end
      assign shuffled[ln*LANE_W + k*DW_W +: DW_W] = pick;
    end
  end
endmodule

// File: rtl/dbsad_superblock.sv
module dbsad_superblock (
  input  logic [63:0] statBytes,
  input  logic [63:0] slideBytes,
  output logic [63:0] sadWords
);
  import dbsad_pkg::*;

  function automatic logic [SAD_W-1:0] absDiff(input logic [BYTE_W-1:0] a,
                                               input logic [BYTE_W-1:0] b);
    logic [BYTE_W-1:0] d;
    d = (a > b) ? (a - b) : (b - a);
    return {{(SAD_W-BYTE_W){1'b0}}, d};
  endfunction

  for (genvar w = 0; w < 4; w++) begin : g_word
    localparam int STAT_BASE = (w < 2) ? 0 : 4;
    logic [SAD_W-1:0] term [4];
    logic [SAD_W-1:0] sumLo, sumHi, total;
    for (genvar i = 0; i < 4; i++) begin : g_term
      assign term[i] = absDiff(statBytes[(STAT_BASE+i)*BYTE_W +: BYTE_W],
                               slideBytes[(w+i)*BYTE_W +: BYTE_W]);
    end
    assign sumLo = term[0] + term[1];
    assign sumHi = term[2] + term[3];
    assign total = sumLo + sumHi;
    assign sadWords[w*WORD_W +: WORD_W] = {{(WORD_W-SAD_W){1'b0}}, total};
  end
endmodule

// File: rtl/dbsad_datapath.sv
module dbsad_datapath #(
  parameter int VEC_W = 128
) (
  input  logic                      clk,
  input  dbsad_pkg::dbsadStrobe_t   strobes,
  input  logic [VEC_W-1:0]          srcA,
  input  logic [VEC_W-1:0]          srcB,
  input  logic [7:0]                shufCtl,
  input  logic [VEC_W/16-1:0]       wordMask,
  input  logic                      maskEnable,
  input  logic                      zeroMode,
  input  logic [VEC_W-1:0]          priorDest,
  output logic [VEC_W-1:0]          result
);
  import dbsad_pkg::*;
  localparam int N_SB    = VEC_W / SB_W;
  localparam int N_WORDS = VEC_W / WORD_W;

  logic [VEC_W-1:0] tmpVec;
  logic [VEC_W-1:0] sadVec;
  logic [VEC_W-1:0] nextRes;

  dbsad_lane_shuffle #(.VEC_W(VEC_W)) shuffle_i (
    .srcB     (srcB),
    .shufCtl  (shufCtl),
    .shuffled (tmpVec)
  );

  for (genvar s = 0; s < N_SB; s++) begin : g_sb
    dbsad_superblock sb_i (
      .statBytes  (srcA[s*SB_W +: SB_W]),
      .slideBytes (tmpVec[s*SB_W +: SB_W]),
      .sadWords   (sadVec[s*SB_W +: SB_W])
    );
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_mask
    logic take;
    assign take = !maskEnable || wordMask[j];
    assign nextRes[j*WORD_W +: WORD_W] =
      take     ? sadVec[j*WORD_W +: WORD_W] :
      zeroMode ? '0 : priorDest[j*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk) begin
    if (strobes.flush)        result <= '0;
    else if (strobes.capture) result <= nextRes;
  end

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (strobes.flush)
    !strobes.capture |=> $stable(result));
  assert_sad_bound_R5: assert property (@(posedge clk) disable iff (strobes.flush)
    (strobes.capture && !maskEnable) |=> (result[15:11] == 5'd0));
  assert_merge_keeps_R7: assert property (@(posedge clk) disable iff (strobes.flush)
    (strobes.capture && maskEnable && !zeroMode && !wordMask[0])
      |=> (result[15:0] == $past(priorDest[15:0])));
  assert_zero_clears_R8: assert property (@(posedge clk) disable iff (strobes.flush)
    (strobes.capture && maskEnable && zeroMode && !wordMask[0])
      |=> (result[15:0] == 16'd0));
endmodule

// File: rtl/dbsad_ctrl.sv
module dbsad_ctrl (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    inValid,
  output dbsad_pkg::dbsadStrobe_t strobes,
  output logic                    outValid
);
  always_comb begin
    strobes.flush   = rst;
    strobes.capture = inValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_idle_no_valid_R10: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/dbsad_unit.sv
module dbsad_unit #(
  parameter int VEC_W = 128
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [VEC_W-1:0]    srcA,
  input  logic [VEC_W-1:0]    srcB,
  input  logic [7:0]          shufCtl,
  input  logic [VEC_W/16-1:0] wordMask,
  input  logic                maskEnable,
  input  logic                zeroMode,
  input  logic [VEC_W-1:0]    priorDest,
  output logic                outValid,
  output logic [VEC_W-1:0]    result
);
  dbsad_pkg::dbsadStrobe_t strobes;

  dbsad_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  dbsad_datapath #(.VEC_W(VEC_W)) dp_i (
    .clk        (clk),
    .strobes    (strobes),
    .srcA       (srcA),
    .srcB       (srcB),
    .shufCtl    (shufCtl),
    .wordMask   (wordMask),
    .maskEnable (maskEnable),
    .zeroMode   (zeroMode),
    .priorDest  (priorDest),
    .result     (result)
  );
endmodule

// File: tb/dbsad_unit_tb.sv
module dbsad_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VW = 256;
  localparam int NW = VW / 16;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst;
  logic inValid;
  logic [VW-1:0] srcA, srcB, priorDest;
  logic [7:0] shufCtl;
  logic [NW-1:0] wordMask;
  logic maskEnable, zeroMode;
  logic outValid;
  logic [VW-1:0] result;

  int checks = 0;
  int errors = 0;
  bit started = 1'b0;
  bit finished = 1'b0;
  string curReq = "R11";

  logic expValid;
  logic [VW-1:0] expRes;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbsad_unit #(.VEC_W(VW)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .shufCtl(shufCtl), .wordMask(wordMask), .maskEnable(maskEnable),
    .zeroMode(zeroMode), .priorDest(priorDest), .outValid(outValid),
    .result(result)
  );

  function automatic logic [VW-1:0] refModel(
      input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [7:0] imm,
      input logic [NW-1:0] m, input logic men, input logic zm,
      input logic [VW-1:0] prior);
    logic [VW-1:0] t;
    logic [VW-1:0] r;
    for (int l = 0; l < VW/128; l++)
      for (int k = 0; k < 4; k++) begin
        int sel;
        sel = int'(imm[2*k +: 2]);
        t[l*128 + k*32 +: 32] = b[l*128 + sel*32 +: 32];
      end
    for (int sb = 0; sb < VW/64; sb++)
      for (int w = 0; w < 4; w++) begin
        int s, base;
        s = 0;
        base = (w < 2) ? 0 : 4;
        for (int i = 0; i < 4; i++) begin
          int x, y;
          x = int'(a[sb*64 + (base+i)*8 +: 8]);
          y = int'(t[sb*64 + (w+i)*8 +: 8]);
          s += (x > y) ? (x - y) : (y - x);
        end
        r[sb*64 + w*16 +: 16] = 16'(s);
      end
    for (int j = 0; j < NW; j++)
      if (men && !m[j]) r[j*16 +: 16] = zm ? 16'd0 : prior[j*16 +: 16];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expValid <= 1'b0;
      expRes   <= '0;
    end else begin
      expValid <= inValid;
      if (inValid)
        expRes <= refModel(srcA, srcB, shufCtl, wordMask, maskEnable, zeroMode, priorDest);
    end
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      checks++;
      if (outValid !== expValid || result !== expRes) begin
        errors++;
        $display("FAIL %s: outValid=%b result=%h expected outValid=%b result=%h",
                 curReq, outValid, result, expValid, expRes);
      end
    end
  end

  function automatic logic [VW-1:0] rndVec();
    logic [VW-1:0] v;
    for (int i = 0; i < VW/32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic drive(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [7:0] imm, input logic [NW-1:0] m,
                       input logic men, input logic zm, input logic [VW-1:0] prior);
    @(posedge clk);
    #1;
    inValid = v; srcA = a; srcB = b; shufCtl = imm;
    wordMask = m; maskEnable = men; zeroMode = zm; priorDest = prior;
  endtask

  task automatic checkWord(input string req, input int idx, input logic [15:0] expv);
    checks++;
    if (result[idx*16 +: 16] !== expv) begin
      errors++;
      $display("FAIL %s: word %0d actual=%0d expected=%0d", req, idx, result[idx*16 +: 16], expv);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    inValid = 1'b1; srcA = rndVec(); srcB = rndVec(); shufCtl = 8'hE4;
    wordMask = '1; maskEnable = 1'b0; zeroMode = 1'b0; priorDest = rndVec();
    @(posedge clk);
    #1 started = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset cleared despite inValid high
    checks++;
    if (outValid !== 1'b0 || result !== '0) begin
      errors++;
      $display("FAIL R11: outValid=%b result=%h expected 0 and 0", outValid, result);
    end
    drive(1'b0, rndVec(), rndVec(), 8'h00, '0, 1'b0, 1'b0, rndVec());
    #1 rst = 1'b0;

    // R1 R2 R3 R4: every shuffle control, masking off
    curReq = "R1/R2/R3/R4";
    for (int imm = 0; imm < 256; imm++)
      drive(1'b1, rndVec(), rndVec(), 8'(imm), NW'($urandom), 1'b0, 1'($urandom), rndVec());

    // R5: byte extremes
    curReq = "R5";
    drive(1'b1, '0, '1, 8'($urandom), '0, 1'b0, 1'b0, rndVec());
    drive(1'b0, rndVec(), rndVec(), 8'h00, '0, 1'b0, 1'b0, rndVec());
    @(negedge clk);
    for (int j = 0; j < NW; j++) checkWord("R5", j, 16'd1020);
    drive(1'b1, '1, '0, 8'($urandom), '1, 1'b1, 1'b1, rndVec());
    drive(1'b1, '1, '1, 8'h1B, '0, 1'b0, 1'b0, rndVec());

    // R6: mask bits ignored when masking disabled
    curReq = "R6";
    for (int n = 0; n < 20; n++)
      drive(1'b1, rndVec(), rndVec(), 8'($urandom), NW'($urandom), 1'b0, 1'($urandom), rndVec());

    // R7 and R8: all ones, all zeros, random masks in both modes
    for (int zm = 0; zm < 2; zm++) begin
      curReq = (zm == 0) ? "R7" : "R8";
      drive(1'b1, rndVec(), rndVec(), 8'($urandom), '1, 1'b1, 1'(zm), rndVec());
      drive(1'b1, rndVec(), rndVec(), 8'($urandom), '0, 1'b1, 1'(zm), rndVec());
      for (int n = 0; n < 30; n++)
        drive(1'b1, rndVec(), rndVec(), 8'($urandom), NW'($urandom), 1'b1, 1'(zm), rndVec());
    end

    // R9 and R10: idle gaps with changing inputs
    curReq = "R9/R10";
    for (int n = 0; n < 40; n++)
      drive(1'($urandom), rndVec(), rndVec(), 8'($urandom), NW'($urandom),
            1'($urandom), 1'($urandom), rndVec());
    drive(1'b0, rndVec(), rndVec(), 8'($urandom), NW'($urandom), 1'b1, 1'b1, rndVec());
    repeat (3) drive(1'b0, rndVec(), rndVec(), 8'($urandom), '0, 1'b1, 1'b1, rndVec());

    // R11: reset mid-stream
    curReq = "R11";
    drive(1'b1, rndVec(), rndVec(), 8'($urandom), '1, 1'b0, 1'b0, rndVec());
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    drive(1'b0, rndVec(), rndVec(), 8'h00, '0, 1'b0, 1'b0, rndVec());
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule